// File: doc/BRIEF.md
# Commit Entry and Rename Register Allocator

This block tracks in-flight instructions for an out-of-order core. At issue, a group of up to four instructions asks for one commit entry each, plus at most one rename register from one of three pools: integer, floating-point basic set, or floating-point extended set. The group is either granted in full or stalled. The granted entries and registers belong to those instructions until they retire.

Execution logic reports completion by entry number. Entries then retire strictly in allocation order, several per cycle. Each retiring entry returns its commit entry and its rename register to the free counts. An exception input drops every in-flight instruction in one edge, so the issue stage can allocate again on the next cycle. Execution units and reservation stations sit outside this block.

Top module: `commit_tracker`

## Requirements
- R1: After reset, the four free counts read full: 48 commit entries, 32 integer, 48 fp-basic and 48 fp-extended registers. `cmt_valid` reads zero.
- R2: Each lane has a 2-bit kind code: 0 = no register, 1 = integer, 2 = fp-basic, 3 = fp-extended. `iss_accept` is high only when all of these hold: at least one lane is valid, the commit free count covers every valid lane, and each pool's free count covers the lanes of that kind. Otherwise nothing is allocated.
- R3: The valid lanes of a granted group receive consecutive entry numbers in ascending lane order. Numbering starts at the allocation pointer and wraps from 47 to 0.
- R4: On the edge that takes a granted group, the commit free count falls by the number of valid lanes. Each pool count falls by the number of lanes of its kind.
- R5: A completion report naming an entry that is not in flight is ignored. A later allocation of that entry starts out incomplete.
- R6: Entries retire oldest first, and only once completed. A completed entry waits while any older entry is still incomplete.
- R7: At most four entries retire per cycle. They appear on `cmt_valid` lanes contiguous from lane 0, with their numbers on `cmt_tag`. A completion taken at edge N can first retire at edge N+1.
- R8: On the edge an entry retires, its commit entry and rename register return to the free counts.
- R9: A cycle with `flush` high grants no issue. On its edge, every count returns to full and `cmt_valid` clears.
- R10: The cycle right after a flush can grant an issue group, starting again at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 4 | Per-lane issue request |
| iss_kind | input | 8 | Per-lane rename kind, 2 bits per lane, lane 0 in the low bits |
| iss_accept | output | 1 | Whole group granted this cycle |
| iss_tag | output | 24 | Per-lane granted entry number, 6 bits per lane |
| cmp_valid | input | 4 | Completion report valid, per port |
| cmp_tag | input | 24 | Completed entry number, 6 bits per port |
| flush | input | 1 | Exception: release everything in flight |
| cmt_valid | output | 4 | Retire lanes, registered, contiguous from lane 0 |
| cmt_tag | output | 24 | Retired entry numbers, 6 bits per lane |
| cse_free | output | 6 | Free commit entries |
| int_free | output | 6 | Free integer rename registers |
| fpb_free | output | 6 | Free fp-basic rename registers |
| fpx_free | output | 6 | Free fp-extended rename registers |

## Verification
Several properties are checked on every cycle:
- The commit free count balances: it moves only by granted lanes and retired lanes.
- No group is granted past the free commit count, and none is granted during a flush.
- Retire lanes stay contiguous.
- Counts are full right after a flush.

Some behaviour only the bench scenarios can show:
- Out-of-order completion being held back until older entries complete.
- Pointer wrap-around.
- Per-pool exhaustion.
- The four-per-cycle retire limit when eight entries are ready.
- A stray completion after a flush leaving a reallocated entry incomplete.

// File: rtl/commit_tracker_pkg.sv
package commit_tracker_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_INT  = 2'd1,
    RK_FPB  = 2'd2,
    RK_FPX  = 2'd3
  } ren_kind_e;

  localparam int NUM_POOLS = 3;

  function automatic int ring_add(input int base, input int inc, input int modulus);
    int s;
    s = base + inc;
    return (s >= modulus) ? s - modulus : s;
  endfunction

endpackage

// File: rtl/commit_tracker_issue.sv
module commit_tracker_issue
  import commit_tracker_pkg::*;
#(
  parameter int ISSUE_W = 4,
  parameter int ENTRIES = 48,
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 6,
  parameter int PW      = 6,
  parameter int NW      = 3
) (
  input  logic                     rst,
  input  logic                     flush,
  input  logic [ISSUE_W-1:0]       lane_valid,
  input  logic [2*ISSUE_W-1:0]     lane_kind,
  input  logic [IDX_W-1:0]         tail,
  input  logic [CNT_W-1:0]         cse_free,
  input  logic [PW-1:0]            pool_free [NUM_POOLS],
  output logic                     accept,
  output logic [ISSUE_W*IDX_W-1:0] lane_tag,
  output logic [NW-1:0]            n_alloc,
  output logic [NW-1:0]            need [NUM_POOLS]
);

  always_comb begin
    int rank;
    int cnt [NUM_POOLS];
    logic fits;
    rank = 0;
    for (int p = 0; p < NUM_POOLS; p++) cnt[p] = 0;
    for (int i = 0; i < ISSUE_W; i++) begin
      lane_tag[i*IDX_W +: IDX_W] = IDX_W'(ring_add(int'(tail), rank, ENTRIES));
      if (lane_valid[i]) begin
        rank = rank + 1;
        if (ren_kind_e'(lane_kind[2*i +: 2]) != RK_NONE)
          cnt[int'(lane_kind[2*i +: 2]) - 1] = cnt[int'(lane_kind[2*i +: 2]) - 1] + 1;
      end
    end
    fits = (rank != 0) && (rank <= int'(cse_free));
    for (int p = 0; p < NUM_POOLS; p++) begin
      need[p] = NW'(cnt[p]);
      if (cnt[p] > int'(pool_free[p])) fits = 1'b0;
    end
    n_alloc = NW'(rank);
    accept  = fits && !rst && !flush;
  end

endmodule

// File: rtl/commit_tracker_pool.sv
module commit_tracker_pool #(
  parameter int DEPTH = 32,
  parameter int PW    = 6,
  parameter int TW    = 3,
  parameter int GW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [TW-1:0] take,
  input  logic [GW-1:0] give,
  output logic [PW-1:0] free_cnt
);

  always_ff @(posedge clk) begin
    if (rst || flush) free_cnt <= PW'(DEPTH);
    else              free_cnt <= free_cnt - PW'(take) + PW'(give);
  end

endmodule

// File: rtl/commit_tracker_ring.sv
module commit_tracker_ring
  import commit_tracker_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int ISSUE_W = 4,
  parameter int CMP_W   = 4,
  parameter int CMT_W   = 4,
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 6,
  parameter int NW      = 3,
  parameter int CW      = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     alloc_en,
  input  logic [ISSUE_W-1:0]       lane_valid,
  input  logic [2*ISSUE_W-1:0]     lane_kind,
  input  logic [ISSUE_W*IDX_W-1:0] lane_tag,
  input  logic [NW-1:0]            n_alloc,
  input  logic [CMP_W-1:0]         cmp_valid,
  input  logic [CMP_W*IDX_W-1:0]   cmp_tag,
  output logic [IDX_W-1:0]         tail,
  output logic [CNT_W-1:0]         cse_free,
  output logic [CMT_W-1:0]         cmt_valid,
  output logic [CMT_W*IDX_W-1:0]   cmt_tag,
  output logic [CW-1:0]            give [NUM_POOLS]
);

  logic [ENTRIES-1:0] busy_q;
  logic [ENTRIES-1:0] done_q;
  ren_kind_e          kind_mem [ENTRIES];
  logic [IDX_W-1:0]   head_q;
  logic [IDX_W-1:0]   tail_q;
  logic [CNT_W-1:0]   used_q;

  logic [CMT_W-1:0]       fire;
  logic [IDX_W-1:0]       sel_idx [CMT_W];
  logic [CMT_W*IDX_W-1:0] sel_flat;
  logic [CW-1:0]          n_cmt;

  // Oldest-first retire window: stops at the first entry not yet complete.
  always_comb begin
    logic run;
    int   nc;
    run = 1'b1;
    nc  = 0;
    for (int p = 0; p < NUM_POOLS; p++) give[p] = '0;
    for (int k = 0; k < CMT_W; k++) begin
      sel_idx[k] = IDX_W'(ring_add(int'(head_q), k, ENTRIES));
      sel_flat[k*IDX_W +: IDX_W] = sel_idx[k];
      if (run && busy_q[sel_idx[k]] && done_q[sel_idx[k]]) begin
        fire[k] = 1'b1;
        nc = nc + 1;
        if (kind_mem[sel_idx[k]] != RK_NONE)
          give[int'(kind_mem[sel_idx[k]]) - 1] = give[int'(kind_mem[sel_idx[k]]) - 1] + CW'(1);
      end else begin
        fire[k] = 1'b0;
        run = 1'b0;
      end
    end
    n_cmt = CW'(nc);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy_q    <= '0;
      done_q    <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      used_q    <= '0;
      cmt_valid <= '0;
      cmt_tag   <= '0;
    end else begin
      for (int k = 0; k < CMT_W; k++)
        if (fire[k]) busy_q[sel_idx[k]] <= 1'b0;
      for (int c = 0; c < CMP_W; c++)
        if (cmp_valid[c] && (int'(cmp_tag[c*IDX_W +: IDX_W]) < ENTRIES) &&
            busy_q[cmp_tag[c*IDX_W +: IDX_W]])
          done_q[cmp_tag[c*IDX_W +: IDX_W]] <= 1'b1;
      if (alloc_en) begin
        for (int i = 0; i < ISSUE_W; i++)
          if (lane_valid[i]) begin
            busy_q[lane_tag[i*IDX_W +: IDX_W]] <= 1'b1;
            done_q[lane_tag[i*IDX_W +: IDX_W]] <= 1'b0;
          end
      end
      head_q <= IDX_W'(ring_add(int'(head_q), int'(n_cmt), ENTRIES));
      tail_q <= IDX_W'(ring_add(int'(tail_q), alloc_en ? int'(n_alloc) : 0, ENTRIES));
      used_q <= used_q + (alloc_en ? CNT_W'(n_alloc) : '0) - CNT_W'(n_cmt);
      cmt_valid <= fire;
      cmt_tag   <= sel_flat;
    end
  end

  // Kind storage: written only at allocation, never reset.
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      for (int i = 0; i < ISSUE_W; i++)
        if (lane_valid[i])
          kind_mem[lane_tag[i*IDX_W +: IDX_W]] <= ren_kind_e'(lane_kind[2*i +: 2]);
    end
  end

  assign tail     = tail_q;
  assign cse_free = CNT_W'(ENTRIES) - used_q;

endmodule

// File: rtl/commit_tracker.sv
module commit_tracker
  import commit_tracker_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int ISSUE_W = 4,
  parameter int CMP_W   = 4,
  parameter int CMT_W   = 4,
  parameter int INT_REN = 32,
  parameter int FP_REN  = 48
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [ISSUE_W-1:0]                       iss_valid,
  input  logic [2*ISSUE_W-1:0]                     iss_kind,
  output logic                                     iss_accept,
  output logic [ISSUE_W*$clog2(ENTRIES)-1:0]       iss_tag,
  input  logic [CMP_W-1:0]                         cmp_valid,
  input  logic [CMP_W*$clog2(ENTRIES)-1:0]         cmp_tag,
  input  logic                                     flush,
  output logic [CMT_W-1:0]                         cmt_valid,
  output logic [CMT_W*$clog2(ENTRIES)-1:0]         cmt_tag,
  output logic [$clog2(ENTRIES+1)-1:0]             cse_free,
  output logic [$clog2(((INT_REN > FP_REN) ? INT_REN : FP_REN)+1)-1:0] int_free,
  output logic [$clog2(((INT_REN > FP_REN) ? INT_REN : FP_REN)+1)-1:0] fpb_free,
  output logic [$clog2(((INT_REN > FP_REN) ? INT_REN : FP_REN)+1)-1:0] fpx_free
);

  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int CNT_W    = $clog2(ENTRIES + 1);
  localparam int POOL_MAX = (INT_REN > FP_REN) ? INT_REN : FP_REN;
  localparam int PW       = $clog2(POOL_MAX + 1);
  localparam int NW       = $clog2(ISSUE_W + 1);
  localparam int CW       = $clog2(CMT_W + 1);

  logic [IDX_W-1:0] tail;
  logic [NW-1:0]    n_alloc;
  logic [NW-1:0]    need      [NUM_POOLS];
  logic [CW-1:0]    give      [NUM_POOLS];
  logic [PW-1:0]    pool_free [NUM_POOLS];

  commit_tracker_issue #(
    .ISSUE_W(ISSUE_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .PW(PW), .NW(NW)
  ) u_issue (
    .rst       (rst),
    .flush     (flush),
    .lane_valid(iss_valid),
    .lane_kind (iss_kind),
    .tail      (tail),
    .cse_free  (cse_free),
    .pool_free (pool_free),
    .accept    (iss_accept),
    .lane_tag  (iss_tag),
    .n_alloc   (n_alloc),
    .need      (need)
  );

  commit_tracker_ring #(
    .ENTRIES(ENTRIES), .ISSUE_W(ISSUE_W), .CMP_W(CMP_W), .CMT_W(CMT_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .NW(NW), .CW(CW)
  ) u_ring (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .alloc_en  (iss_accept),
    .lane_valid(iss_valid),
    .lane_kind (iss_kind),
    .lane_tag  (iss_tag),
    .n_alloc   (n_alloc),
    .cmp_valid (cmp_valid),
    .cmp_tag   (cmp_tag),
    .tail      (tail),
    .cse_free  (cse_free),
    .cmt_valid (cmt_valid),
    .cmt_tag   (cmt_tag),
    .give      (give)
  );

  for (genvar g = 0; g < NUM_POOLS; g++) begin : g_pool
    localparam int DEPTH = (g == 0) ? INT_REN : FP_REN;
    logic [NW-1:0] take;
    assign take = iss_accept ? need[g] : '0;
    commit_tracker_pool #(
      .DEPTH(DEPTH), .PW(PW), .TW(NW), .GW(CW)
    ) u_pool (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .take    (take),
      .give    (give[g]),
      .free_cnt(pool_free[g])
    );
  end

  assign int_free = pool_free[0];
  assign fpb_free = pool_free[1];
  assign fpx_free = pool_free[2];

endmodule

// File: rtl/commit_tracker_chk.sv
module commit_tracker_chk #(
  parameter int ENTRIES = 48,
  parameter int ISSUE_W = 4,
  parameter int CMT_W   = 4,
  parameter int INT_REN = 32,
  parameter int FP_REN  = 48,
  parameter int CNT_W   = 6,
  parameter int PW      = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [ISSUE_W-1:0] iss_valid,
  input logic               iss_accept,
  input logic               flush,
  input logic [CMT_W-1:0]   cmt_valid,
  input logic [CNT_W-1:0]   cse_free,
  input logic [PW-1:0]      int_free,
  input logic [PW-1:0]      fpb_free,
  input logic [PW-1:0]      fpx_free
);

  assert_reject_short_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones(iss_valid) > int'(cse_free)) |-> !iss_accept);

  assert_accept_needs_lane_R2: assert property (@(posedge clk) disable iff (rst)
    iss_accept |-> (iss_valid != '0));

  assert_cse_balance_R4: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (int'(cse_free) == int'($past(cse_free))
                - ($past(iss_accept) ? $countones($past(iss_valid)) : 0)
                + $countones(cmt_valid)));

  assert_retire_contig_R7: assert property (@(posedge clk) disable iff (rst)
    ((cmt_valid & (cmt_valid + 1'b1)) == '0));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(cse_free) <= ENTRIES) && (int'(int_free) <= INT_REN) &&
    (int'(fpb_free) <= FP_REN) && (int'(fpx_free) <= FP_REN));

  assert_flush_full_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> ((int'(cse_free) == ENTRIES) && (int'(int_free) == INT_REN) &&
               (int'(fpb_free) == FP_REN) && (int'(fpx_free) == FP_REN) &&
               (cmt_valid == '0)));

  assert_no_issue_in_flush_R9: assert property (@(posedge clk) disable iff (rst)
    flush |-> !iss_accept);

endmodule

bind commit_tracker commit_tracker_chk #(
  .ENTRIES(ENTRIES), .ISSUE_W(ISSUE_W), .CMT_W(CMT_W),
  .INT_REN(INT_REN), .FP_REN(FP_REN),
  .CNT_W($clog2(ENTRIES + 1)),
  .PW($clog2(((INT_REN > FP_REN) ? INT_REN : FP_REN) + 1))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .iss_valid (iss_valid),
  .iss_accept(iss_accept),
  .flush     (flush),
  .cmt_valid (cmt_valid),
  .cse_free  (cse_free),
  .int_free  (int_free),
  .fpb_free  (fpb_free),
  .fpx_free  (fpx_free)
);

// File: tb/commit_tracker_tb.sv
module commit_tracker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  iss_valid = '0;
  logic [7:0]  iss_kind = '0;
  logic        iss_accept;
  logic [23:0] iss_tag;
  logic [3:0]  cmp_valid = '0;
  logic [23:0] cmp_tag = '0;
  logic        flush = 1'b0;
  logic [3:0]  cmt_valid;
  logic [23:0] cmt_tag;
  logic [5:0]  cse_free, int_free, fpb_free, fpx_free;

  int checks = 0;
  int errors = 0;
  int nxt = 0;
  logic [36:0] vec;

  always #4 clk = ~clk;

  commit_tracker u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .iss_accept(iss_accept), .iss_tag(iss_tag), .cmp_valid(cmp_valid),
    .cmp_tag(cmp_tag), .flush(flush), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
    .cse_free(cse_free), .int_free(int_free), .fpb_free(fpb_free), .fpx_free(fpx_free)
  );

  // {mask, kinds, accept, cse, int, fpb, fpx after the edge}
  localparam logic [36:0] VEC [16] = '{
    {4'b1111, 8'b11100101, 1'b1, 6'd44, 6'd30, 6'd47, 6'd47},
    {4'b0101, 8'b00010000, 1'b1, 6'd42, 6'd29, 6'd47, 6'd47},
    {4'b1111, 8'b01010101, 1'b1, 6'd38, 6'd25, 6'd47, 6'd47},
    {4'b1111, 8'b01010101, 1'b1, 6'd34, 6'd21, 6'd47, 6'd47},
    {4'b1111, 8'b01010101, 1'b1, 6'd30, 6'd17, 6'd47, 6'd47},
    {4'b1111, 8'b01010101, 1'b1, 6'd26, 6'd13, 6'd47, 6'd47},
    {4'b1111, 8'b01010101, 1'b1, 6'd22, 6'd9,  6'd47, 6'd47},
    {4'b1111, 8'b01010101, 1'b1, 6'd18, 6'd5,  6'd47, 6'd47},
    {4'b1111, 8'b01010101, 1'b1, 6'd14, 6'd1,  6'd47, 6'd47},
    {4'b0011, 8'b00000101, 1'b0, 6'd14, 6'd1,  6'd47, 6'd47},
    {4'b0001, 8'b00000001, 1'b1, 6'd13, 6'd0,  6'd47, 6'd47},
    {4'b1111, 8'b00111010, 1'b1, 6'd9,  6'd0,  6'd45, 6'd46},
    {4'b1111, 8'b00000000, 1'b1, 6'd5,  6'd0,  6'd45, 6'd46},
    {4'b1111, 8'b00000000, 1'b1, 6'd1,  6'd0,  6'd45, 6'd46},
    {4'b0011, 8'b00000000, 1'b0, 6'd1,  6'd0,  6'd45, 6'd46},
    {4'b1000, 8'b00000000, 1'b1, 6'd0,  6'd0,  6'd45, 6'd46}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic counts(input string req, input int c, input int i, input int b, input int x);
    chk({req, " cse_free"}, cse_free, c);
    chk({req, " int_free"}, int_free, i);
    chk({req, " fpb_free"}, fpb_free, b);
    chk({req, " fpx_free"}, fpx_free, x);
  endtask

  task automatic complete(input int t0, input int t1, input int t2, input int t3,
                          input logic [3:0] m);
    cmp_valid = m;
    cmp_tag   = {6'(t3), 6'(t2), 6'(t1), 6'(t0)};
    tick();
    cmp_valid = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    counts("R1 reset", 48, 32, 48, 48);
    chk("R1 cmt_valid", cmt_valid, 0);

    // Table: R2 grant, R3 tags, R4 count drop
    for (int v = 0; v < 16; v++) begin
      int r;
      vec = VEC[v];
      iss_valid = vec[36:33];
      iss_kind  = vec[32:25];
      #1;
      chk("R2 accept", iss_accept, vec[24]);
      r = 0;
      if (vec[24]) begin
        for (int l = 0; l < 4; l++)
          if (iss_valid[l]) begin
            chk("R3 tag", iss_tag[l*6 +: 6], (nxt + r) % 48);
            r++;
          end
      end
      tick();
      iss_valid = '0;
      nxt = (nxt + r) % 48;
      counts("R4 table", vec[23:18], vec[17:12], vec[11:6], vec[5:0]);
    end

    // R6: younger entry done, older not -> no retire
    complete(1, 0, 0, 0, 4'b0001);
    tick();
    chk("R6 hold cmt_valid", cmt_valid, 0);
    chk("R6 hold cse_free", cse_free, 0);

    // R6/R8: older completes, both retire together
    complete(0, 0, 0, 0, 4'b0001);
    tick();
    chk("R6 pair cmt_valid", cmt_valid, 4'b0011);
    chk("R6 pair tag0", cmt_tag[5:0], 0);
    chk("R6 pair tag1", cmt_tag[11:6], 1);
    chk("R8 pair cse", cse_free, 2);
    chk("R8 pair int", int_free, 2);

    // R7 timing and R8 per-pool release
    complete(2, 3, 4, 5, 4'b1111);
    complete(6, 7, 8, 9, 4'b1111);
    chk("R7 group cmt_valid", cmt_valid, 4'b1111);
    chk("R7 group tag0", cmt_tag[5:0], 2);
    counts("R8 group", 6, 3, 46, 47);
    tick();
    chk("R7 second cmt_valid", cmt_valid, 4'b1111);
    chk("R7 second tag0", cmt_tag[5:0], 6);
    chk("R8 second int", int_free, 7);
    tick();
    chk("R7 idle cmt_valid", cmt_valid, 0);

    // R7 four-per-cycle limit with eight ready
    complete(14, 15, 16, 17, 4'b1111);
    complete(10, 11, 12, 13, 4'b1111);
    tick();
    chk("R7 limit cmt_valid", cmt_valid, 4'b1111);
    chk("R7 limit tag0", cmt_tag[5:0], 10);
    chk("R7 limit cse", cse_free, 14);
    tick();
    chk("R7 limit next tag0", cmt_tag[5:0], 14);
    chk("R8 limit cse", cse_free, 18);
    chk("R8 limit int", int_free, 15);

    // R3 wrap from 47 to 0
    iss_valid = 4'b1111;
    iss_kind  = '0;
    #1;
    chk("R3 wrap accept", iss_accept, 1);
    for (int l = 0; l < 4; l++) chk("R3 wrap tag", iss_tag[l*6 +: 6], l);
    tick();
    iss_valid = '0;
    chk("R4 wrap cse", cse_free, 14);

    // R9 flush: no grant, everything back
    flush = 1'b1;
    iss_valid = 4'b1111;
    #1;
    chk("R9 flush accept", iss_accept, 0);
    tick();
    flush = 1'b0;
    iss_valid = '0;
    counts("R9 flush", 48, 32, 48, 48);
    chk("R9 flush cmt_valid", cmt_valid, 0);

    // R10 grant right after flush; R5 stray completion of entry 1
    iss_valid = 4'b0001;
    cmp_valid = 4'b0001;
    cmp_tag   = 24'd1;
    #1;
    chk("R10 accept", iss_accept, 1);
    chk("R10 tag", iss_tag[5:0], 0);
    tick();
    iss_valid = '0;
    cmp_valid = '0;
    chk("R10 cse", cse_free, 47);
    iss_valid = 4'b1111;
    iss_kind  = 8'b01010101;
    #1;
    chk("R5 realloc tag1", iss_tag[5:0], 1);
    tick();
    iss_valid = '0;
    counts("R5 realloc", 43, 28, 48, 48);
    complete(0, 0, 0, 0, 4'b0001);
    tick();
    chk("R5 stray ignored cmt_valid", cmt_valid, 4'b0001);
    chk("R5 stray ignored cse", cse_free, 44);

    // R1 reset mid-run
    rst = 1'b1;
    tick();
    rst = 1'b0;
    counts("R1 rereset", 48, 32, 48, 48);
    chk("R1 rereset cmt_valid", cmt_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule